// File: doc/BRIEF.md
# Butterfly Multiply with Rounding Shift

This block performs one fixed-point butterfly step of the kind found in FFT and DCT inner loops. It accepts two signed operands and a signed coefficient. It forms the sum and the difference of the two operands and scales both by the coefficient. Each scaled value is then rounded half-up and shifted right arithmetically by a programmable amount, and the two results come out together one clock later.

Every arithmetic step wraps at XLEN bits. A shift amount of zero is a bypass: the truncated products pass through with no rounding bias and no shift. A shift amount from 1 to XLEN−1 adds a bias of 2^(n−1) before the arithmetic right shift.

Two states govern the output stage. `ST_EMPTY` means no result is presented. `ST_FULL` means a fresh result pair is on the outputs. The transition `take` (in_valid high) moves either state to `ST_FULL`. The transition `drain` (in_valid low) moves either state to `ST_EMPTY`. Reset forces `ST_EMPTY`.

Top module: `bfly_rshift`

## Requirements
- R1: The sum is in_a+in_b and the difference is in_a−in_b, each wrapped to XLEN bits (two's complement).
- R2: Each of the sum and the difference is multiplied by the signed in_coef, and only the low XLEN bits of each product are kept.
- R3: For in_shamt ≠ 0, the value 2^(in_shamt−1) is added to each truncated product before shifting (round half up).
- R4: After rounding, each value is shifted right by in_shamt with the vacated upper bits filled from the sign bit of the rounded value. For in_shamt = XLEN−1 every result is therefore 0 or all ones.
- R5: For in_shamt = 0, out_sum and out_diff equal the truncated products unchanged.
- R6: The rounding addition wraps modulo 2^XLEN with no overflow indication. For example, a product of 2^(XLEN−1)−1 with in_shamt = 1 gives 0xC000…0.
- R7: out_valid is high exactly in the cycle after a cycle with in_valid high. The results load only on in_valid and hold otherwise.
- R8: A synchronous active-high rst clears out_valid and both results in the next cycle. An in_valid presented together with rst is dropped.
- R9: out_sum and out_diff are produced in the same cycle from the same in_shamt and in_coef. With in_a=0xA71, in_b=0xE6B8, in_coef=0x2D41 (XLEN=64), in_shamt=14 gives 0xAA86 and 0xFFFFFFFFFFFF643E, and in_shamt=0 gives 0x2AA17069 and 0xFFFFFFFFD90F96F9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands valid this cycle |
| in_a | input | XLEN | First signed operand |
| in_b | input | XLEN | Second signed operand |
| in_coef | input | XLEN | Signed coefficient |
| in_shamt | input | $clog2(XLEN) | Right shift amount, 0 selects bypass |
| out_valid | output | 1 | Result pair valid |
| out_sum | output | XLEN | Rounded, shifted (a+b)·coef |
| out_diff | output | XLEN | Rounded, shifted (a−b)·coef |

## Verification
Two effects can land in the same result: the rounding bias carry and the sign fill of the arithmetic shift. When a product sits at the largest positive value, the bias wraps it negative, and the shift must then fill with ones rather than zeros. The bench provokes this with in_a = 2^(XLEN−1)−1, in_b = 0, in_coef = 1 and in_shamt = 1, and it judges the outcome against 0xC000…0 on both outputs. It also issues back-to-back operations, so a new operand load and the presentation of the previous result share a clock edge, and the scoreboard confirms the order is kept.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

    // Output stage occupancy
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } out_state_e;

    // Lane selector for the generate loop
    localparam int LANE_SUM  = 0;
    localparam int LANE_DIFF = 1;
    localparam int N_LANES   = 2;

endpackage

// File: rtl/bfly_mul_lane.sv
// One scaling lane: wrap-around product of an operand with the coefficient.
module bfly_mul_lane #(
    parameter int XLEN = 64
) (
    input  logic signed [XLEN-1:0] opnd,
    input  logic signed [XLEN-1:0] coef,
    output logic signed [XLEN-1:0] prod
);
    // Self-determined XLEN-wide signed multiply keeps the low XLEN bits.
    always_comb begin
        prod = opnd * coef;
    end
endmodule

// File: rtl/bfly_round_shift.sv
// Round half-up, then arithmetic right shift; shift of zero is a bypass.
module bfly_round_shift #(
    parameter int XLEN = 64,
    parameter int SHW  = $clog2(XLEN)
) (
    input  logic signed [XLEN-1:0] prod,
    input  logic        [SHW-1:0]  shamt,
    output logic signed [XLEN-1:0] res
);
    localparam logic [XLEN-1:0] ONE = {{(XLEN-1){1'b0}}, 1'b1};

    logic [XLEN-1:0]        bias;
    logic signed [XLEN-1:0] biased;
    logic                   bypass;

    always_comb begin
        bypass = (shamt == '0);
        bias   = bypass ? '0 : (ONE << (shamt - SHW'(1)));
        // Wraps modulo 2^XLEN by width
        biased = prod + $signed(bias);
        res    = bypass ? prod : (biased >>> shamt);
    end
endmodule

// File: rtl/bfly_rshift.sv
module bfly_rshift
    import bfly_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int SHW  = $clog2(XLEN)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [XLEN-1:0] in_a,
    input  logic [XLEN-1:0] in_b,
    input  logic [XLEN-1:0] in_coef,
    input  logic [SHW-1:0]  in_shamt,
    output logic            out_valid,
    output logic [XLEN-1:0] out_sum,
    output logic [XLEN-1:0] out_diff
);
    out_state_e state_q, state_d;

    logic signed [XLEN-1:0] lane_in  [N_LANES];
    logic signed [XLEN-1:0] lane_prd [N_LANES];
    logic signed [XLEN-1:0] lane_res [N_LANES];

    // Sum and difference wrap at XLEN
    always_comb begin
        lane_in[LANE_SUM]  = $signed(in_a + in_b);
        lane_in[LANE_DIFF] = $signed(in_a - in_b);
    end

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        bfly_mul_lane #(.XLEN(XLEN)) u_mul (
            .opnd (lane_in[g]),
            .coef ($signed(in_coef)),
            .prod (lane_prd[g])
        );
        bfly_round_shift #(.XLEN(XLEN), .SHW(SHW)) u_rs (
            .prod  (lane_prd[g]),
            .shamt (in_shamt),
            .res   (lane_res[g])
        );
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_EMPTY;
        else     state_q <= state_d;
    end

    // Next state: take / drain
    always_comb begin
        unique case (state_q)
            ST_EMPTY: state_d = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_d = in_valid ? ST_FULL : ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst) begin
            out_sum  <= '0;
            out_diff <= '0;
        end else if (in_valid) begin
            out_sum  <= lane_res[LANE_SUM];
            out_diff <= lane_res[LANE_DIFF];
        end
    end

    always_comb begin
        out_valid = (state_q == ST_FULL);
    end
endmodule

// File: rtl/bfly_rshift_chk.sv
module bfly_rshift_chk #(
    parameter int XLEN = 64,
    parameter int SHW  = $clog2(XLEN)
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [XLEN-1:0] in_a,
    input logic [XLEN-1:0] in_b,
    input logic [XLEN-1:0] in_coef,
    input logic [SHW-1:0]  in_shamt,
    input logic            out_valid,
    input logic [XLEN-1:0] out_sum,
    input logic [XLEN-1:0] out_diff
);
    localparam logic [SHW-1:0]  TOP_SH = SHW'(XLEN-1);
    localparam logic [XLEN-1:0] UNIT   = {{(XLEN-1){1'b0}}, 1'b1};

    logic rst_d = 1'b0;
    always_ff @(posedge clk) rst_d <= rst;

    // R8
    always @(negedge clk) begin
        if (rst_d) begin
            reset_clear_chk: assert (!out_valid && out_sum == '0 && out_diff == '0);
        end
    end

    // R7
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R7
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_sum) && $stable(out_diff)));

    // R4
    sign_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_shamt == TOP_SH) |=>
        ((out_sum == '0 || out_sum == '1) && (out_diff == '0 || out_diff == '1)));

    // R5
    bypass_ident_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_shamt == '0 && in_coef == UNIT && in_b == '0) |=>
        (out_sum == $past(in_a) && out_diff == $past(in_a)));
endmodule

bind bfly_rshift bfly_rshift_chk #(.XLEN(XLEN), .SHW(SHW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .in_coef   (in_coef),
    .in_shamt  (in_shamt),
    .out_valid (out_valid),
    .out_sum   (out_sum),
    .out_diff  (out_diff)
);

// File: tb/test_bfly_rshift.sv
`timescale 1ns/1ps
module test_bfly_rshift;
    localparam int XLEN = 64;
    localparam int SHW  = 6;

    typedef struct {
        logic [63:0] s;
        logic [63:0] d;
        string       tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic [63:0]     in_a = '0, in_b = '0, in_coef = '0;
    logic [SHW-1:0]  in_shamt = '0;
    logic            out_valid;
    logic [63:0]     out_sum, out_diff;

    int total = 0;
    int bad   = 0;
    exp_t sb[$];

    always #4 clk = ~clk;

    bfly_rshift #(.XLEN(XLEN)) i_bfly_rshift (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_a(in_a), .in_b(in_b), .in_coef(in_coef), .in_shamt(in_shamt),
        .out_valid(out_valid), .out_sum(out_sum), .out_diff(out_diff)
    );

    // Behavioural model: wrap arithmetic, round half up, arithmetic shift
    function automatic logic [63:0] model(logic signed [63:0] a, logic signed [63:0] b,
                                          logic signed [63:0] c, int n, bit dif);
        logic signed [63:0] t;
        logic signed [63:0] p;
        t = dif ? (a - b) : (a + b);
        p = t * c;
        if (n == 0) return p;
        p = p + (64'sd1 <<< (n - 1));
        return p >>> n;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: present one operation for one cycle, push expectation
    task automatic drive(logic [63:0] a, logic [63:0] b, logic [63:0] c, int n, string tag);
        exp_t e;
        @(negedge clk);
        in_a = a; in_b = b; in_coef = c; in_shamt = SHW'(n); in_valid = 1'b1;
        e.s = model(a, b, c, n, 1'b0);
        e.d = model(a, b, c, n, 1'b1);
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(int cyc);
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: compare results as they appear
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (out_valid === 1'b1) begin
                if (sb.size() == 0) begin
                    check("R7 unexpected out_valid", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check({e.tag, " sum"},  out_sum,  e.s);
                    check({e.tag, " diff"}, out_diff, e.d);
                end
            end
        end
    end

    initial begin
        #1_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] hs, hd;
        repeat (3) @(negedge clk);
        #1;
        check("R8 reset out_valid", {63'd0, out_valid}, 64'd0);
        check("R8 reset out_sum", out_sum, 64'd0);
        @(negedge clk);
        rst = 1'b0;

        // R9 known vectors, both lanes in the same cycle
        drive(64'h0A71, 64'hE6B8, 64'h2D41, 14, "R9 n14");
        idle(1);
        #2;
        check("R9 n14 literal sum", out_sum, 64'h0000_0000_0000_AA86);
        check("R9 n14 literal diff", out_diff, 64'hFFFF_FFFF_FFFF_643E);
        drive(64'h0A71, 64'hE6B8, 64'h2D41, 0, "R5 n0");
        idle(1);
        #2;
        check("R5 n0 literal sum", out_sum, 64'h0000_0000_2AA1_7069);
        check("R5 n0 literal diff", out_diff, 64'hFFFF_FFFF_D90F_96F9);

        // R6 rounding carry wraps into sign, R4 fill with ones
        drive(64'h7FFF_FFFF_FFFF_FFFF, 64'd0, 64'd1, 1, "R6 wrap");
        idle(1);
        #2;
        check("R6 wrap literal sum", out_sum, 64'hC000_0000_0000_0000);

        // R1 wrap of sum and difference, R2 truncated product
        drive(64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, 64'h3, 0, "R1 R2 wrap");
        drive(64'h8000_0000_0000_0000, 64'h1, 64'hFFFF_FFFF_FFFF_FFFD, 5, "R1 R2 neg");
        // R3 round-half-up exact half: 3*1 with n=1 -> 2; -3 -> -1
        drive(64'd3, 64'd0, 64'd1, 1, "R3 half");
        drive(64'hFFFF_FFFF_FFFF_FFFD, 64'd0, 64'd1, 1, "R3 neghalf");
        idle(2);

        // R4 every shift amount, back-to-back
        for (int n = 0; n < XLEN; n++) begin
            drive({$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom}, n, "R4 sweep");
        end
        drive({$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom}, XLEN-1, "R4 top");
        drive(64'h8000_0000_0000_0000, 64'd0, 64'd1, XLEN-1, "R4 top neg");
        idle(2);

        // Random mix with gaps
        for (int k = 0; k < 300; k++) begin
            drive({$urandom, $urandom}, {$urandom, $urandom}, 64'($signed($urandom % 65536) - 32768),
                  int'($urandom % XLEN), "R2 random");
            if ($urandom % 4 == 0) idle(1);
        end
        idle(2);

        // R7 hold while idle
        drive(64'd1234, 64'd77, 64'd9, 3, "R7 load");
        idle(1);
        #2;
        hs = out_sum; hd = out_diff;
        idle(4);
        #2;
        check("R7 idle out_valid", {63'd0, out_valid}, 64'd0);
        check("R7 hold sum", out_sum, hs);
        check("R7 hold diff", out_diff, hd);

        // R8 operation presented with reset is dropped
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1; in_a = 64'd5; in_b = 64'd1; in_coef = 64'd2; in_shamt = '0;
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        #2;
        check("R8 drop out_valid", {63'd0, out_valid}, 64'd0);
        check("R8 clear diff", out_diff, 64'd0);
        idle(2);

        check("R7 scoreboard empty", 64'(sb.size()), 64'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule